// File: doc/BRIEF.md
# Programmable Target Up-Counter with Alarm Interrupt

This peripheral keeps a wide up-counter that is compared on every clock against a software-written target. In one-shot mode the counter parks on the target when it reaches it and flags an interrupt. Counting picks up again only after software writes a fresh target. In periodic mode the counter flags the interrupt and starts again from zero. An all-ones target keeps the counter running for longer than any practical uptime, so it can act as a plain timebase that software reads and converts to wall-clock time.

Software sees the block through a small register window of `WORD_W`-bit words on a 4-byte stride. The target and the live count are each split into a low word and a high word. There is also a control word and a pending-status word. The count is read high, low, high; if the two high reads differ, software reads again.

A three-state controller sequences the counter. The states are `ST_OFF` (stopped, count held), `ST_RUN` (counting) and `ST_HALT` (one-shot target reached, count held). The transitions are:
- `ST_OFF`→`ST_RUN` on a control write that sets the enable bit while enable is clear ("start").
- `ST_RUN`→`ST_HALT` when count equals target in one-shot mode.
- `ST_HALT`→`ST_RUN` on any write to a target word ("resume").
- `ST_RUN`/`ST_HALT`→`ST_OFF` on a control write with the enable bit clear ("stop").

Top module: `up_alarm_timer`

## Requirements
- R1: After reset every register reads zero (target, count, control, status) and `irq` is low; the state is `ST_OFF`.
- R2: A control write (offset 0x10) with bit 0 = 1 while enable is clear loads the count with zero and enters `ST_RUN`. In `ST_RUN` the count then rises by one per clock while it differs from the target.
- R3: With control bit 1 = 1 (one-shot), a clock in `ST_RUN` where count equals target sets the status bit and moves to `ST_HALT`, and the count stays at the target.
- R4: With control bit 1 = 0 (periodic), a clock in `ST_RUN` where count equals target sets the status bit and returns the count to zero, and counting continues.
- R5: In `ST_HALT`, a write to the target low word (0x00) or high word (0x04) returns the controller to `ST_RUN`. Counting resumes from the held value.
- R6: A control write with bit 0 = 0 enters `ST_OFF`. There the count holds and no match can set status, even if the target is changed.
- R7: Writing a word with bit 0 = 1 to offset 0x18 clears the status bit. A match on the same clock wins, so status stays set.
- R8: `irq` is high exactly when the status bit is set and control bit 2 (interrupt unmask) is 1.
- R9: A write to 0x00 changes only target bits `WORD_W-1:0`. A write to 0x04 changes only the upper word. Both read back at those offsets.
- R10: The count reads at 0x08 (low word) and 0x0C (high word). The increment carries from the low word into the high word on the same clock.
- R11: Control reads at 0x10 in bits 2:0 and status at 0x18 in bit 0, with all other bits zero. Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | WORD_W | Write data |
| rsp_rdata | output | WORD_W | Combinational read data for `req_addr` |
| irq | output | 1 | Level interrupt, status AND unmask |

## Verification
The bound checker watches every clock for the stepping rules. It checks the single-step increment in `ST_RUN`, the hold in `ST_OFF`, and the clear-and-enter on start. It also checks the target-match outcomes of both modes, the resume on a target write from `ST_HALT`, the status set/clear priority and the interrupt gating. The bench scenarios show what depends on register decode and on long sequences. Those are word-wise target writes, the zero read of unmapped offsets, the low-to-high carry seen through the count words, a re-write of enable that must not restart the count, and a clear that loses against a match on the same clock.

// File: rtl/atm_pkg.sv
package atm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } atm_state_e;

    // Byte offsets of the register window
    localparam int unsigned OFS_TGT   = 'h00;
    localparam int unsigned OFS_CNT   = 'h08;
    localparam int unsigned OFS_CTRL  = 'h10;
    localparam int unsigned OFS_STS   = 'h18;
    localparam int unsigned WORD_STEP = 4;

    // Control field positions
    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_ONESHOT = 1;
    localparam int unsigned CTL_UNMASK  = 2;
    localparam int unsigned CTL_BITS    = 3;

endpackage

// File: rtl/atm_regfile.sv
module atm_regfile
    import atm_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORDS  = 2,
    localparam int unsigned CNT_W = WORD_W * WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [CNT_W-1:0]    count,
    input  logic                hit,
    output logic [CNT_W-1:0]    tgt_q,
    output logic [CTL_BITS-1:0] ctrl_q,
    output logic                status_q,
    output logic                tgt_wr,
    output logic                ctrl_wr,
    output logic [WORD_W-1:0]   rdata
);

    logic          wr_en;
    logic          sts_clr;
    logic [WORDS-1:0] tgt_word_wr;

    assign wr_en   = req_valid && req_write;
    assign ctrl_wr = wr_en && (req_addr == ADDR_W'(OFS_CTRL));
    assign sts_clr = wr_en && (req_addr == ADDR_W'(OFS_STS)) && req_wdata[0];
    assign tgt_wr  = |tgt_word_wr;

    // One register per target word
    for (genvar w = 0; w < WORDS; w++) begin : g_tgt
        assign tgt_word_wr[w] = wr_en &&
            (req_addr == ADDR_W'(OFS_TGT + WORD_STEP * w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tgt_q[w*WORD_W +: WORD_W] <= '0;
            end else if (tgt_word_wr[w]) begin
                tgt_q[w*WORD_W +: WORD_W] <= req_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= req_wdata[CTL_BITS-1:0];
        end
    end

    // A match on the same clock outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (sts_clr) begin
            status_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (req_addr == ADDR_W'(OFS_TGT + WORD_STEP * w)) begin
                rdata = tgt_q[w*WORD_W +: WORD_W];
            end
            if (req_addr == ADDR_W'(OFS_CNT + WORD_STEP * w)) begin
                rdata = count[w*WORD_W +: WORD_W];
            end
        end
        if (req_addr == ADDR_W'(OFS_CTRL)) begin
            rdata = WORD_W'(ctrl_q);
        end
        if (req_addr == ADDR_W'(OFS_STS)) begin
            rdata = WORD_W'(status_q);
        end
    end

endmodule

// File: rtl/atm_fsm.sv
module atm_fsm
    import atm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_enable_bit,
    input  logic       en_q,
    input  logic       oneshot,
    input  logic       tgt_wr,
    input  logic       at_target,
    output atm_state_e state,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       hit
);

    atm_state_e state_d;
    logic       start;
    logic       stop;

    assign start = ctrl_wr && wr_enable_bit && !en_q;
    assign stop  = ctrl_wr && !wr_enable_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF: begin
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (stop)                       state_d = ST_OFF;
                else if (at_target && oneshot)  state_d = ST_HALT;
            end
            ST_HALT: begin
                if (stop)         state_d = ST_OFF;
                else if (tgt_wr)  state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        hit     = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state)
            ST_OFF: begin
                cnt_clr = start;
            end
            ST_RUN: begin
                hit     = at_target;
                cnt_clr = at_target && !oneshot && !stop;
                cnt_inc = !at_target && !stop;
            end
            ST_HALT: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/atm_counter.sv
module atm_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/up_alarm_timer.sv
module up_alarm_timer
    import atm_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              irq
);

    localparam int unsigned WORDS = 2;
    localparam int unsigned CNT_W = WORD_W * WORDS;

    logic [CNT_W-1:0]    count_q;
    logic [CNT_W-1:0]    tgt_q;
    logic [CTL_BITS-1:0] ctrl_q;
    logic                status_q;
    logic                tgt_wr;
    logic                ctrl_wr;
    logic                cnt_clr;
    logic                cnt_inc;
    logic                hit;
    atm_state_e          fsm_state;

    atm_regfile #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .WORDS  (WORDS)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .count     (count_q),
        .hit       (hit),
        .tgt_q     (tgt_q),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q),
        .tgt_wr    (tgt_wr),
        .ctrl_wr   (ctrl_wr),
        .rdata     (rsp_rdata)
    );

    atm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .wr_enable_bit (req_wdata[CTL_EN]),
        .en_q          (ctrl_q[CTL_EN]),
        .oneshot       (ctrl_q[CTL_ONESHOT]),
        .tgt_wr        (tgt_wr),
        .at_target     (count_q == tgt_q),
        .state         (fsm_state),
        .cnt_clr       (cnt_clr),
        .cnt_inc       (cnt_inc),
        .hit           (hit)
    );

    atm_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count_q)
    );

    assign irq = status_q && ctrl_q[CTL_UNMASK];

endmodule

// File: rtl/atm_checker.sv
module atm_checker
    import atm_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned CNT_W = 2 * WORD_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [WORD_W-1:0]   req_wdata,
    input atm_state_e          state,
    input logic [CNT_W-1:0]    count,
    input logic [CNT_W-1:0]    tgt,
    input logic [CTL_BITS-1:0] ctrl_q,
    input logic                status_q,
    input logic                irq
);

    logic c_wr, c_ctrl_wr, c_tgt_wr, c_sts_clr, c_match;

    assign c_wr      = req_valid && req_write;
    assign c_ctrl_wr = c_wr && (req_addr == ADDR_W'(OFS_CTRL));
    assign c_tgt_wr  = c_wr && ((req_addr == ADDR_W'(OFS_TGT)) ||
                                (req_addr == ADDR_W'(OFS_TGT + WORD_STEP)));
    assign c_sts_clr = c_wr && (req_addr == ADDR_W'(OFS_STS)) && req_wdata[0];
    assign c_match   = (state == ST_RUN) && (count == tgt);

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && count != tgt && !c_ctrl_wr)
        |=> (count == $past(count) + CNT_W'(1)));

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && c_ctrl_wr && req_wdata[CTL_EN])
        |=> (count == '0 && state == ST_RUN));

    a_r3_halt_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        (c_match && ctrl_q[CTL_ONESHOT] && !c_ctrl_wr)
        |=> (state == ST_HALT && $stable(count)));

    a_r3_match_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        c_match |=> status_q);

    a_r4_periodic_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (c_match && !ctrl_q[CTL_ONESHOT] && !c_ctrl_wr)
        |=> (count == '0 && state == ST_RUN));

    a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && c_tgt_wr && !c_ctrl_wr)
        |=> (state == ST_RUN));

    a_r6_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !(c_ctrl_wr && req_wdata[CTL_EN]))
        |=> ($stable(count) && state == ST_OFF));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sts_clr && !c_match) |=> !status_q);

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q && ctrl_q[CTL_UNMASK]));

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && ctrl_q[CTL_UNMASK]) |-> irq);

endmodule

bind up_alarm_timer atm_checker #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_atm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (fsm_state),
    .count     (count_q),
    .tgt       (tgt_q),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .irq       (irq)
);

// File: tb/test_up_alarm_timer.sv
module test_up_alarm_timer;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned CNT_W  = 2 * WORD_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic [WORD_W-1:0] rsp_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    up_alarm_timer #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) i_up_alarm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    // Behavioural reference: 0 stopped, 1 counting, 2 parked
    logic [CNT_W-1:0] m_tgt = '0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic [2:0]       m_ctl = '0;
    logic             m_sts = 1'b0;
    int               m_mode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tgt = '0; m_cnt = '0; m_ctl = '0; m_sts = 1'b0; m_mode = 0;
        end else begin
            bit wr, c_wr, t_wr, s_clr, go, halt_req, matched;
            logic [2:0] old_ctl;
            wr       = req_valid && req_write;
            c_wr     = wr && req_addr == 5'h10;
            t_wr     = wr && (req_addr == 5'h00 || req_addr == 5'h04);
            s_clr    = wr && req_addr == 5'h18 && req_wdata[0];
            old_ctl  = m_ctl;
            go       = c_wr && req_wdata[0] && !old_ctl[0];
            halt_req = c_wr && !req_wdata[0];
            matched  = (m_mode == 1) && (m_cnt == m_tgt);
            if (go) begin
                m_cnt = '0; m_mode = 1;
            end else if (m_mode == 1) begin
                if (matched) begin
                    if (halt_req) m_mode = 0;
                    else if (old_ctl[1]) m_mode = 2;
                    else m_cnt = '0;
                end else if (halt_req) m_mode = 0;
                else m_cnt = m_cnt + 1'b1;
            end else if (m_mode == 2) begin
                if (halt_req) m_mode = 0;
                else if (t_wr) m_mode = 1;
            end
            if (matched) m_sts = 1'b1;
            else if (s_clr) m_sts = 1'b0;
            if (wr && req_addr == 5'h00) m_tgt[7:0]  = req_wdata;
            if (wr && req_addr == 5'h04) m_tgt[15:8] = req_wdata;
            if (c_wr) m_ctl = req_wdata[2:0];
        end
    end

    function automatic logic [WORD_W-1:0] m_read(logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   return m_tgt[7:0];
            5'h04:   return m_tgt[15:8];
            5'h08:   return m_cnt[7:0];
            5'h0C:   return m_cnt[15:8];
            5'h10:   return {5'b0, m_ctl};
            5'h18:   return {7'b0, m_sts};
            default: return '0;
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_sts && m_ctl[2])) begin
                errors++;
                $display("FAIL R8 model irq: actual %0b expected %0b t=%0t",
                         irq, m_sts && m_ctl[2], $time);
            end
            checks++;
            if (rsp_rdata !== m_read(req_addr)) begin
                errors++;
                $display("FAIL R11 model read @%h: actual %h expected %h t=%0t",
                         req_addr, rsp_rdata, m_read(req_addr), $time);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rsp_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [WORD_W-1:0] v;
        idle(4);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        rd(5'h00, v); chk("R1 target lo", v, 0);
        rd(5'h04, v); chk("R1 target hi", v, 0);
        rd(5'h08, v); chk("R1 count lo", v, 0);
        rd(5'h0C, v); chk("R1 count hi", v, 0);
        rd(5'h10, v); chk("R1 ctrl", v, 0);
        rd(5'h18, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);

        // R9: word-wise target writes
        wr(5'h00, 8'h34); wr(5'h04, 8'h12);
        rd(5'h00, v); chk("R9 lo readback", v, 8'h34);
        rd(5'h04, v); chk("R9 hi readback", v, 8'h12);
        wr(5'h00, 8'h10);
        rd(5'h04, v); chk("R9 hi untouched by lo write", v, 8'h12);

        // R11: unmapped offsets
        wr(5'h14, 8'hFF); wr(5'h02, 8'hAA);
        rd(5'h14, v); chk("R11 unmapped 0x14", v, 0);
        rd(5'h1C, v); chk("R11 unmapped 0x1C", v, 0);
        rd(5'h00, v); chk("R11 target lo unchanged", v, 8'h10);
        rd(5'h10, v); chk("R11 ctrl unchanged", v, 0);

        // R3: one-shot to target 5, parks with irq
        wr(5'h00, 8'h05); wr(5'h04, 8'h00);
        wr(5'h10, 8'h07);
        idle(20);
        rd(5'h08, v); chk("R3 parked count lo", v, 8'h05);
        rd(5'h18, v); chk("R3 status set", v, 1);
        chk("R8 irq unmasked", irq, 1);

        // R7: clear
        wr(5'h18, 8'h01);
        rd(5'h18, v); chk("R7 status cleared", v, 0);
        chk("R7 irq low", irq, 0);

        // R5/R10: resume on target hi write, carry into high word
        wr(5'h04, 8'h01);
        idle(300);
        rd(5'h0C, v); chk("R10 count hi after carry", v, 8'h01);
        rd(5'h08, v); chk("R5 parked at new target lo", v, 8'h05);
        rd(5'h18, v); chk("R5 status after resume", v, 1);

        // R8: mask while pending; re-enable write must not restart
        wr(5'h10, 8'h03);
        chk("R8 irq masked", irq, 0);
        rd(5'h08, v); chk("R2 no restart on enable rewrite", v, 8'h05);

        // R6: stop holds count and ignores target changes
        wr(5'h10, 8'h00);
        wr(5'h18, 8'h01);
        wr(5'h04, 8'hFF); wr(5'h00, 8'h05);
        idle(10);
        rd(5'h08, v); chk("R6 held lo", v, 8'h05);
        rd(5'h0C, v); chk("R6 held hi", v, 8'h01);
        rd(5'h18, v); chk("R6 no match while stopped", v, 0);

        // R4: periodic with target 3
        wr(5'h00, 8'h03); wr(5'h04, 8'h00);
        wr(5'h10, 8'h01);
        idle(10);
        rd(5'h18, v); chk("R4 periodic status", v, 1);
        rd(5'h08, v); chk("R4 count wrapped within target", v <= 8'h03, 1);
        rd(5'h0C, v); chk("R4 count hi stays zero", v, 0);

        // R7: match outranks a clear on the same clock
        wr(5'h10, 8'h00);
        wr(5'h00, 8'h00);
        wr(5'h10, 8'h05);
        wr(5'h18, 8'h01);
        rd(5'h18, v); chk("R7 match beats clear", v, 1);
        chk("R8 irq with match every clock", irq, 1);

        // R2: restart from zero and step by one
        wr(5'h10, 8'h00);
        wr(5'h04, 8'hFF);
        wr(5'h10, 8'h07);
        rd(5'h08, v); chk("R2 first step", v, 8'h01);
        rd(5'h08, v); chk("R2 second step", v, 8'h02);
        rd(5'h10, v); chk("R11 ctrl readback", v, 8'h07);

        idle(2);
        finish_run();
    end

endmodule